// File: doc/BRIEF.md
# Asynchronous Character Transmitter with Break

This block serialises characters taken from a transmit buffer onto a single output line. Each character goes out as one frame. A frame starts with a low start bit. The data bits follow, least significant first, and the character length is programmable. An optional parity bit comes next, then one or two high stop bits. An external bit-enable strobe sets the bit rate. Each strobe marks the start of one bit period, so the block itself generates no baud clock.

Nothing is sent until a start command arms the transmitter. While armed, the block takes a character from the buffer at each character boundary where one is offered and the clear-to-send input is high. When it reaches a boundary and finds the buffer empty, it disarms, raises an all-sent flag and leaves the line idle high.

A break input overrides the line and drives it low on the next clock edge, even in the middle of a frame. Frame timing keeps running underneath the break. The line returns to the frame's level on the first edge after the break input is cleared.

Top module: `serial_char_tx`

## Requirements
- R1: After reset the line is 1, all_sent is 0 and buf_pop is 0. No character is taken while the transmitter is not armed, even when buf_valid is high. Only a start_cmd pulse arms it.
- R2: Data bits go out least significant bit first, one bit per bit period.
- R3: A frame is one 0 start bit, then the data field, then the optional parity bit, then the stop bits. cfg_len values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, taken from the low bits of buf_data.
- R4: cfg_two_stop = 0 gives one stop bit at 1. cfg_two_stop = 1 gives two stop bits at 1.
- R5: cfg_par selects the parity bit: 0 none (no bit), 1 even (the count of ones over data and parity is even), 2 odd, 3 always 1, 4 always 0. Codes 5 to 7 act as none.
- R6: An armed transmitter that reaches a character boundary with buf_valid low disarms and raises all_sent. While all_sent is high the line is 1, unless a break is applied. start_cmd clears all_sent.
- R7: send_ok is sampled only at a character boundary. While it is low no character is taken. A frame already under way always completes.
- R8: While brk_cmd is high the line is 0 from the next clock edge on. On the first edge after brk_cmd falls, the line shows the frame's current bit, or idle 1.
- R9: The frame advances one bit on each clock where bit_en is high. Without a strobe or a break change, the line holds its value.
- R10: buf_pop is a one-cycle pulse, high in the cycle of the strobe that loads buf_data. That strobe's edge puts the start bit on the line, and back-to-back characters leave no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-period strobe |
| start_cmd | input | 1 | Pulse that arms transmission |
| send_ok | input | 1 | Clear-to-send, sampled at character boundaries |
| brk_cmd | input | 1 | Break: force the line low while high |
| cfg_len | input | 2 | Character length code (5 + value bits) |
| cfg_two_stop | input | 1 | Two stop bits when high |
| cfg_par | input | 3 | Parity mode code |
| buf_valid | input | 1 | Buffer offers a character |
| buf_data | input | 8 | Offered character |
| buf_pop | output | 1 | Character taken this cycle |
| tx_line | output | 1 | Serial output line |
| all_sent | output | 1 | Buffer drained and line idle |

## Verification
The assertions assume three things about the inputs. bit_en is a clean single-cycle strobe. buf_data is stable while buf_valid is high until buf_pop takes it. brk_cmd is low during reset. The bench drives every input one half clock away from the sampling edge. It generates bit_en from a divider, serves buf_valid and buf_data from its own queue, and removes a character only when its model predicts a pop. It changes configuration only while the transmitter is idle. Under these conditions a frame never sees a change in buffer contents or in configuration.

// File: rtl/stx_pkg.sv
`timescale 1ns/1ps
package stx_pkg;
    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_EVEN  = 3'd1,
        PAR_ODD   = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_mode_e;
endpackage

// File: rtl/stx_parity.sv
`timescale 1ns/1ps
module stx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_masked,
    input  logic [2:0]        mode,
    output logic              par_en,
    output logic              par_bit
);
    import stx_pkg::*;

    logic ones_odd;

    always_comb begin
        ones_odd = ^data_masked;
        par_en   = 1'b1;
        par_bit  = 1'b0;
        case (mode)
            PAR_EVEN:  par_bit = ones_odd;
            PAR_ODD:   par_bit = ~ones_odd;
            PAR_MARK:  par_bit = 1'b1;
            PAR_SPACE: par_bit = 1'b0;
            default:   par_en  = 1'b0;
        endcase
    end
endmodule

// File: rtl/stx_frame_build.sv
`timescale 1ns/1ps
module stx_frame_build #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2,
    parameter int FRAME_W = DATA_W + 4,
    parameter int CNT_W   = 4
) (
    input  logic [DATA_W-1:0]  data,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic               cfg_two_stop,
    input  logic [2:0]         cfg_par,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   nbits
);
    logic [DATA_W-1:0] masked;
    logic              par_en;
    logic              par_bit;
    int                len;
    int                pos;

    always_comb begin
        len = MIN_LEN + int'(cfg_len);
        if (len > DATA_W) len = DATA_W;
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = (i < len) ? data[i] : 1'b0;
        end
    end

    stx_parity #(.DATA_W(DATA_W)) u_par (
        .data_masked(masked),
        .mode       (cfg_par),
        .par_en     (par_en),
        .par_bit    (par_bit)
    );

    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < len) frame[i+1] = masked[i];
        end
        pos = len + 1;
        if (par_en) begin
            frame[pos] = par_bit;
            pos        = pos + 1;
        end
        nbits = CNT_W'(pos + (cfg_two_stop ? 2 : 1));
    end
endmodule

// File: rtl/serial_char_tx.sv
`timescale 1ns/1ps
module serial_char_tx #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              start_cmd,
    input  logic              send_ok,
    input  logic              brk_cmd,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_two_stop,
    input  logic [2:0]        cfg_par,
    input  logic              buf_valid,
    input  logic [DATA_W-1:0] buf_data,
    output logic              buf_pop,
    output logic              tx_line,
    output logic              all_sent
);
    localparam int LEN_W   = 2;
    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   left;
        logic               run;
        logic               done;
        logic               line;
    } tx_state_t;

    tx_state_t st_d, st_q;

    logic [FRAME_W-1:0] fb_frame;
    logic [CNT_W-1:0]   fb_nbits;
    logic               boundary;
    logic               load;
    logic               line_bit;

    stx_frame_build #(
        .DATA_W (DATA_W),
        .MIN_LEN(MIN_LEN),
        .LEN_W  (LEN_W),
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) u_build (
        .data        (buf_data),
        .cfg_len     (cfg_len),
        .cfg_two_stop(cfg_two_stop),
        .cfg_par     (cfg_par),
        .frame       (fb_frame),
        .nbits       (fb_nbits)
    );

    always_comb begin
        boundary = (st_q.left <= CNT_W'(1));
        load     = bit_en && boundary && st_q.run && buf_valid && send_ok;
        st_d     = st_q;
        if (bit_en) begin
            if (!boundary) begin
                st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
                st_d.left  = st_q.left - CNT_W'(1);
            end else if (load) begin
                st_d.frame = fb_frame;
                st_d.left  = fb_nbits;
            end else begin
                st_d.frame = '1;
                st_d.left  = '0;
                if (st_q.run && !buf_valid) begin
                    st_d.run  = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end
        if (start_cmd) begin
            st_d.run  = 1'b1;
            st_d.done = 1'b0;
        end
        line_bit  = (st_d.left != '0) ? st_d.frame[0] : 1'b1;
        st_d.line = brk_cmd ? 1'b0 : line_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.frame <= '1;
            st_q.left  <= '0;
            st_q.run   <= 1'b0;
            st_q.done  <= 1'b0;
            st_q.line  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_pop  = load;
    assign tx_line  = st_q.line;
    assign all_sent = st_q.done;
endmodule

// File: rtl/stx_checker.sv
`timescale 1ns/1ps
module stx_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic send_ok,
    input logic brk_cmd,
    input logic buf_valid,
    input logic buf_pop,
    input logic tx_line,
    input logic all_sent
);
    AST_NO_POP_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        all_sent |-> !buf_pop);  // R1
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_pop && !brk_cmd) |=> !tx_line);  // R3
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (all_sent && !brk_cmd) |=> tx_line);  // R6
    AST_POP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop |-> (bit_en && send_ok && buf_valid));  // R7
    AST_BRK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        brk_cmd |=> !tx_line);  // R8
    AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !brk_cmd && !$past(brk_cmd)) |=> $stable(tx_line));  // R9
    AST_POP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop |=> !buf_pop);  // R10
endmodule

bind serial_char_tx stx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .send_ok  (send_ok),
    .brk_cmd  (brk_cmd),
    .buf_valid(buf_valid),
    .buf_pop  (buf_pop),
    .tx_line  (tx_line),
    .all_sent (all_sent)
);

// File: tb/tb_serial_char_tx.sv
`timescale 1ns/1ps
module tb_serial_char_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, start_cmd = 1'b0, send_ok = 1'b1, brk_cmd = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_two_stop = 1'b0;
    logic [2:0] cfg_par = 3'd0;
    logic       buf_valid = 1'b0;
    logic [7:0] buf_data = 8'h00;
    logic       buf_pop, tx_line, all_sent;

    always #2.5 clk = ~clk;

    serial_char_tx dut (.*);

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    mq[$];
    logic [7:0] bufq[$];
    int    mrun = 0, mdone = 0, mtx = 1;
    int    div = 1, phase = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic build(logic [7:0] d);
        int len = 5 + int'(cfg_len);
        int ones = 0;
        mq.push_back(1'b0);
        for (int i = 0; i < len; i++) begin
            mq.push_back(d[i]);
            ones += d[i];
        end
        case (cfg_par)
            3'd1: mq.push_back(ones % 2 == 1);
            3'd2: mq.push_back(ones % 2 == 0);
            3'd3: mq.push_back(1'b1);
            3'd4: mq.push_back(1'b0);
            default: ;
        endcase
        mq.push_back(1'b1);
        if (cfg_two_stop) mq.push_back(1'b1);
    endtask

    task automatic cycle();
        bit bnd, exp_pop;
        bit_en    = (phase == 0);
        phase     = (phase + 1) % div;
        buf_valid = (bufq.size() != 0);
        buf_data  = buf_valid ? bufq[0] : 8'h00;
        #1;
        bnd     = (mq.size() <= 1);
        exp_pop = bit_en && bnd && (mrun != 0) && buf_valid && send_ok;
        chk(cur_req, "buf_pop", int'(buf_pop), int'(exp_pop));
        @(posedge clk);
        if (bit_en) begin
            if (!bnd) void'(mq.pop_front());
            else begin
                mq.delete();
                if (exp_pop) begin
                    build(buf_data);
                    void'(bufq.pop_front());
                end else if (mrun != 0 && !buf_valid) begin
                    mrun = 0; mdone = 1;
                end
            end
        end
        if (start_cmd) begin mrun = 1; mdone = 0; end
        mtx = brk_cmd ? 0 : (mq.size() != 0 ? int'(mq[0]) : 1);
        @(negedge clk);
        chk(cur_req, "tx_line", int'(tx_line), mtx);
        chk(cur_req, "all_sent", int'(all_sent), mdone);
        start_cmd = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic run_until_done();
        int n = 0;
        do begin cycle(); n++; end
        while (!(mdone == 1 && bufq.size() == 0) && n < 3000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL %s watchdog: actual=hung expected=finished", cur_req);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset tx_line", int'(tx_line), 1);
        chk("R1", "reset all_sent", int'(all_sent), 0);
        chk("R1", "reset buf_pop", int'(buf_pop), 0);

        // R1: buffer offers data but no start command yet
        cur_req = "R1";
        bufq.push_back(8'hA5); bufq.push_back(8'h3C);
        run(20);

        // R2: 8-bit, no parity, one stop, back-to-back
        cur_req = "R2";
        start_cmd = 1'b1;
        run_until_done();
        chk("R6", "all_sent after drain", int'(all_sent), 1);

        // R3: every character length
        cur_req = "R3";
        for (int l = 0; l < 4; l++) begin
            cfg_len = 2'(l);
            bufq.push_back(8'hD6 ^ 8'(l * 37));
            start_cmd = 1'b1;
            run_until_done();
        end

        // R5 and R4: every parity mode with both stop settings
        for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 2; s++) begin
                cur_req = (s == 1) ? "R4" : "R5";
                cfg_par = 3'(p); cfg_two_stop = 1'(s); cfg_len = 2'((p + s) % 4);
                bufq.push_back(8'(8'h5B + p * 17 + s));
                bufq.push_back(8'(8'hE1 - p * 3));
                start_cmd = 1'b1;
                run_until_done();
            end
        end

        // R9: slower strobe
        cur_req = "R9";
        div = 3; phase = 0; cfg_par = 3'd1; cfg_len = 2'd2;
        bufq.push_back(8'h71); bufq.push_back(8'h0E);
        start_cmd = 1'b1;
        run_until_done();

        // R6: start with empty buffer
        cur_req = "R6";
        start_cmd = 1'b1;
        run(8);
        chk("R6", "all_sent on empty start", int'(all_sent), 1);

        // R7: send_ok low before start, then dropped mid-frame
        cur_req = "R7";
        div = 2; phase = 0;
        send_ok = 1'b0;
        bufq.push_back(8'h96);
        start_cmd = 1'b1;
        run(30);
        chk("R7", "held char still queued", bufq.size(), 1);
        send_ok = 1'b1;
        bufq.push_back(8'h4D);
        run(6);
        send_ok = 1'b0;
        run(50);
        send_ok = 1'b1;
        run_until_done();

        // R8: break inside a frame and while idle
        cur_req = "R8";
        div = 2; phase = 0; cfg_len = 2'd3; cfg_par = 3'd2;
        bufq.push_back(8'hFF); bufq.push_back(8'h81);
        start_cmd = 1'b1;
        run(7);
        brk_cmd = 1'b1;
        run(5);
        brk_cmd = 1'b0;
        run_until_done();
        brk_cmd = 1'b1;
        run(4);
        brk_cmd = 1'b0;
        run(4);

        // R10: back-to-back pops at fastest strobe
        cur_req = "R10";
        div = 1; phase = 0; cfg_len = 2'd0; cfg_par = 3'd0; cfg_two_stop = 1'b0;
        for (int k = 0; k < 5; k++) bufq.push_back(8'(k * 29 + 3));
        start_cmd = 1'b1;
        run_until_done();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule